// File: doc/BRIEF.md
# Boot-Block Flash Lock Guard

This block decides whether a request aimed at a flash array of 1M sixteen-bit words may go ahead. The array uses a top-boot layout. The highest 32K words are split into eight small 4K-word blocks: two boot blocks, then six parameter blocks below them. The remaining space below holds 31 main blocks of 32K words each. The block keeps one lock bit for each of the 39 blocks and a single permanent lock bit. An external sequencer presents an address, an operation code and a valid strobe. One cycle later the block answers with either grant or deny. When an array operation is refused because of a lock, it also raises a locked-block flag.

There are two levels of protection. A block lock bit refuses erase and program on that block. A full-chip erase is refused if any block is locked. The permanent lock bit, once set, freezes every block lock bit. A write-protect input held low treats both boot blocks as locked, whatever their lock bits hold.

In identifier-read mode the block returns fixed data words. These are the manufacturer and device codes, the permanent lock state, and each block's own lock state.

Top module: `flash_lock_guard`

## Requirements
- R1: Block index 0 is the 4K-word block at 0xFF000–0xFFFFF. Indices 1–7 are the 4K-word blocks going downward to 0xF8000. Index 8 is the 32K-word block at 0xF0000. Index 38 is the 32K-word block at 0x00000.
- R2: Operation codes on `op` are as follows: 0 block erase, 1 full-chip erase, 2 program, 3 set block lock, 4 set permanent lock, 5 clear all block locks, 6 identifier read, 7 reserved.
- R2 (timing): Each cycle with `req_valid` high produces exactly one of `grant` or `deny` in the following cycle. Neither output is high otherwise. Code 7 is always denied.
- R3: Block erase and program on a block whose effective lock is set are denied with `lock_err` high. Otherwise they are granted. `lock_err` is never high without `deny`.
- R4: Full-chip erase is denied with `lock_err` if any block's effective lock is set. Otherwise it is granted.
- R5: While `wp_n` is low, blocks 0 and 1 are effectively locked. Other blocks follow only their own lock bits. While `wp_n` is high, blocks 0 and 1 also follow only their own lock bits.
- R6: A granted set-block-lock sets the lock bit of the addressed block. A granted clear-all clears all 39 block lock bits and leaves the permanent bit unchanged.
- R7: Set-permanent-lock is always granted and sets the permanent bit. The bit stays set until reset. While it is set, set-block-lock and clear-all are denied with `lock_err` low, and no block lock bit changes.
- R8: In identifier read, address 0x00000 returns `MFR_CODE` and address 0x00001 returns `DEV_CODE`. Address 0x00003 returns the permanent bit in bit 0, with bits 15:1 zero.
- R9: In identifier read, offset 2 inside any block returns that block's stored lock bit in bit 0, with bits 15:1 zero. Every other identifier address reads 0. `id_data` is 0 in any cycle that does not follow an identifier read.
- R10: After reset all lock bits and the permanent bit are clear, and `grant`, `deny`, `lock_err` and `id_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| op | input | 3 | Operation code (R2) |
| addr | input | 20 | Word address |
| wp_n | input | 1 | Write protect, low protects the boot blocks |
| grant | output | 1 | Request accepted, one cycle after the strobe |
| deny | output | 1 | Request refused, one cycle after the strobe |
| lock_err | output | 1 | Refusal of an array operation caused by a lock |
| id_data | output | 16 | Identifier read data |

## Verification
Every result is registered once. For a request strobed at a rising edge, `grant`, `deny`, `lock_err` and `id_data` are valid after that same edge and are held until the next edge. Lock-state changes from a granted request take effect for the request strobed at the following edge. The bench drives inputs on the falling edge and queues the expected result word when it drives. Its monitor pops and compares that word one nanosecond after the rising edge that samples the request. Back-to-back requests therefore test that a lock change is seen by the very next request.

// File: rtl/flash_lock_guard.sv
module flash_lock_guard #(
  parameter logic [15:0] MFR_CODE = 16'h00B0,
  parameter logic [15:0] DEV_CODE = 16'h00E9,
  parameter int          ADDR_W   = 20,
  parameter int          SMALL_W  = 12,
  parameter int          MAIN_W   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  output logic              grant,
  output logic              deny,
  output logic              lock_err,
  output logic [15:0]       id_data
);
  localparam int N_SMALL = 1 << (MAIN_W - SMALL_W);
  localparam int N_MAIN  = (1 << (ADDR_W - MAIN_W)) - 1;
  localparam int N_BLK   = N_SMALL + N_MAIN;
  localparam int IDX_W   = $clog2(N_BLK);

  localparam logic [2:0] OP_ERASE = 3'd0, OP_CHIP = 3'd1, OP_PROG = 3'd2,
                         OP_SETL  = 3'd3, OP_PERM = 3'd4, OP_CLRL = 3'd5,
                         OP_ID    = 3'd6;

  logic [N_BLK-1:0] lock_q;
  logic             perm_q;

  logic             in_small;
  logic [IDX_W-1:0] blk;
  logic             at_off2;
  logic             blk_locked, any_locked, ok, arr_op;
  logic [15:0]      id_c;

  assign in_small = &addr[ADDR_W-1:MAIN_W];
  assign blk = in_small
    ? IDX_W'(N_SMALL - 1) - IDX_W'(addr[MAIN_W-1:SMALL_W])
    : IDX_W'(N_BLK - 1)   - IDX_W'(addr[ADDR_W-1:MAIN_W]);
  assign at_off2 = in_small ? (addr[SMALL_W-1:0] == SMALL_W'(2))
                            : (addr[MAIN_W-1:0]  == MAIN_W'(2));

  assign blk_locked = lock_q[blk] | (~wp_n & (blk < IDX_W'(2)));
  assign any_locked = (|lock_q) | ~wp_n;
  assign arr_op     = (op == OP_ERASE) | (op == OP_CHIP) | (op == OP_PROG);

  always_comb begin
    case (op)
      OP_ERASE, OP_PROG: ok = ~blk_locked;
      OP_CHIP:           ok = ~any_locked;
      OP_SETL, OP_CLRL:  ok = ~perm_q;
      OP_PERM, OP_ID:    ok = 1'b1;
      default:           ok = 1'b0;
    endcase
  end

  always_comb begin
    if (addr == ADDR_W'(0))      id_c = MFR_CODE;
    else if (addr == ADDR_W'(1)) id_c = DEV_CODE;
    else if (addr == ADDR_W'(3)) id_c = {15'd0, perm_q};
    else if (at_off2)            id_c = {15'd0, lock_q[blk]};
    else                         id_c = 16'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= '0;
      perm_q   <= 1'b0;
      grant    <= 1'b0;
      deny     <= 1'b0;
      lock_err <= 1'b0;
      id_data  <= 16'd0;
    end else begin
      grant    <= req_valid & ok;
      deny     <= req_valid & ~ok;
      lock_err <= req_valid & ~ok & arr_op;
      id_data  <= (req_valid && op == OP_ID) ? id_c : 16'd0;
      if (req_valid && ok) begin
        if (op == OP_SETL) lock_q[blk] <= 1'b1;
        if (op == OP_CLRL) lock_q      <= '0;
        if (op == OP_PERM) perm_q      <= 1'b1;
      end
    end
  end

  p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant ^ deny));
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(grant | deny));
  p_err_needs_deny_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> deny);
  p_perm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);
  p_locks_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> $stable(lock_q));
  p_id_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && op == OP_ID) |=> (id_data == 16'd0));
endmodule

// File: tb/flash_lock_guard_tb.sv
module flash_lock_guard_tb;
  localparam logic [15:0] MFR = 16'h00B0;
  localparam logic [15:0] DEV = 16'h00E9;

  logic        clk = 0, rst_n = 0, req_valid = 0, wp_n = 1;
  logic [2:0]  op = 0;
  logic [19:0] addr = 0;
  logic        grant, deny, lock_err;
  logic [15:0] id_data;

  int total = 0, bad = 0;
  logic [18:0] expq[$];
  string       tagq[$];
  logic        m_lock[39];
  logic        m_perm;

  always #2 clk = ~clk;

  flash_lock_guard u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
    .addr(addr), .wp_n(wp_n), .grant(grant), .deny(deny), .lock_err(lock_err),
    .id_data(id_data));

  function automatic int bidx(logic [19:0] a);
    if (a >= 20'hF8000) return int'((20'hFFFFF - a) >> 12);
    return 38 - int'(a >> 15);
  endfunction

  function automatic logic eff(int b);
    return m_lock[b] || (!wp_n && b <= 1);
  endfunction

  function automatic logic [15:0] idval(logic [19:0] a);
    int b = bidx(a);
    logic [19:0] base = (b < 8) ? (20'hFF000 - 20'(b) * 20'h1000) : 20'((38 - b) * 32768);
    if (a == 0) return MFR;
    if (a == 1) return DEV;
    if (a == 3) return {15'd0, m_perm};
    if (a == base + 2) return {15'd0, m_lock[b]};
    return 16'd0;
  endfunction

  task automatic issue(input logic [2:0] o, input logic [19:0] a, input string tag);
    logic g = 0, e = 0;
    logic [15:0] d = 0;
    int b = bidx(a);
    case (o)
      3'd0, 3'd2: begin g = !eff(b); e = !g; end
      3'd1: begin
        g = 1;
        for (int i = 0; i < 39; i++) if (eff(i)) g = 0;
        e = !g;
      end
      3'd3: begin g = !m_perm; if (g) m_lock[b] = 1; end
      3'd4: begin g = 1; m_perm = 1; end
      3'd5: begin g = !m_perm; if (g) for (int i = 0; i < 39; i++) m_lock[i] = 0; end
      3'd6: begin g = 1; d = idval(a); end
      default: g = 0;
    endcase
    expq.push_back({g, !g, e, d});
    tagq.push_back(tag);
    op = o; addr = a; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got g/d/e/id=%b/%b/%b/%h expected %b/%b/%b/%h", tag,
        act[18], act[17], act[16], act[15:0], exp[18], exp[17], exp[16], exp[15:0]);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && req_valid) begin
      #1;
      if (expq.size() > 0) check(tagq.pop_front(), {grant, deny, lock_err, id_data}, expq.pop_front());
    end else if (rst_n) begin
      #1;
      check("R2 idle", {grant, deny, lock_err, id_data}, 19'd0);
    end
  end

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 39; i++) m_lock[i] = 0;
    m_perm = 0;
    repeat (3) @(negedge clk);
    check("R10 reset", {grant, deny, lock_err, id_data}, 19'd0);
    rst_n = 1;
    @(negedge clk);
    issue(3'd6, 20'h00000, "R8 mfr");
    issue(3'd6, 20'h00001, "R8 dev");
    issue(3'd6, 20'h00003, "R8 perm clear");
    issue(3'd6, 20'h00004, "R9 reserved");
    issue(3'd6, 20'hFF003, "R9 reserved small");
    issue(3'd2, 20'h12345, "R3 program unlocked");
    issue(3'd3, 20'h12000, "R6 set lock");
    issue(3'd2, 20'h12345, "R3 program locked");
    issue(3'd0, 20'h17FFF, "R3 erase locked");
    issue(3'd0, 20'h18000, "R1 neighbour free");
    issue(3'd6, 20'h10002, "R1 R9 lock code");
    issue(3'd1, 20'h00000, "R4 chip locked");
    issue(3'd7, 20'h00000, "R2 reserved op");
    issue(3'd5, 20'h00000, "R6 clear all");
    issue(3'd1, 20'h00000, "R4 chip free");
    wp_n = 0;
    issue(3'd2, 20'hFF800, "R5 boot0 wp");
    issue(3'd0, 20'hFE123, "R5 boot1 wp");
    issue(3'd2, 20'hFD000, "R5 param wp");
    issue(3'd1, 20'h00000, "R4 R5 chip wp");
    wp_n = 1;
    issue(3'd2, 20'hFF800, "R5 boot0 free");
    for (int b = 0; b < 39; b++) begin
      logic [19:0] base = (b < 8) ? (20'hFF000 - 20'(b) * 20'h1000) : 20'((38 - b) * 32768);
      if (b % 3 == 0) issue(3'd3, base + 20'h7, "R1 R6 set each");
    end
    for (int b = 0; b < 39; b++) begin
      logic [19:0] base = (b < 8) ? (20'hFF000 - 20'(b) * 20'h1000) : 20'((38 - b) * 32768);
      issue(3'd6, base + 20'h2, "R1 R9 lock map");
      issue(3'd2, base + 20'h9, "R1 R3 program map");
    end
    issue(3'd5, 20'h00000, "R6 clear again");
    issue(3'd3, 20'hF8010, "R6 lock param5");
    issue(3'd4, 20'h00000, "R7 set perm");
    issue(3'd6, 20'h00003, "R7 R8 perm read");
    issue(3'd5, 20'h00000, "R7 clear denied");
    issue(3'd3, 20'h40000, "R7 set denied");
    issue(3'd6, 20'h40002, "R7 lock unchanged");
    issue(3'd6, 20'hF8002, "R7 lock kept");
    issue(3'd2, 20'hF8010, "R3 R7 program param5");
    issue(3'd0, 20'h40000, "R7 erase free block");
    issue(3'd4, 20'h00000, "R7 perm again");
    repeat (3) @(negedge clk);
    if (expq.size() != 0) begin
      bad++; total++;
      $display("FAIL R2: got %0d pending results expected 0", expq.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule